// File: doc/BRIEF.md
# Interrupt flag and mask unit

This block holds the interrupt bookkeeping registers of a small 8-bit microcontroller: a flag register for the external interrupt, an enable register for the timer overflow interrupt and a flag register for the timer overflow. The core reaches all three through its I/O space. The block takes a one-cycle pulse from the pin edge detector and a one-cycle pulse from the timer on overflow. From these, and from the enable bits, it produces one interrupt request and the vector number the core should take.

Each flag can be cleared in two ways. Software writes a one to the flag bit, or the core acknowledges the matching vector. If a set event arrives in the same cycle as either clear, the set wins, so no event is lost. When the external interrupt is in level mode, its flag is held at zero. The request then follows the live pin level, qualified by the enables.

Top module: `irq_flag_unit`

## Requirements
- R1: After reset, all three registers read 0x00, `irq_req` is 0 and `irq_vec` is 0.
- R2: While `io_re` is high, `io_rdata` shows in the same cycle the addressed register. The external flag is bit 6 at address 0x3A. The timer enable is bit 1 at address 0x39. The timer flag is bit 1 at address 0x38. Every other bit reads 0, and any other address reads 0x00.
- R3: A write to 0x39 loads bit 1 of the write data into the timer enable. The other bits of the write are ignored.
- R4: An `ext_edge_pulse` in edge mode sets the external flag on the next clock edge. A `tmr_ovf_pulse` sets the timer flag on the next clock edge.
- R5: Writing 1 to a flag bit at its address clears that flag. Writing 0 to it, or writing to any other bit, leaves the flag unchanged.
- R6: When `vec_ack` is high with `irq_req` high, the flag of the vector shown on `irq_vec` is cleared on that clock edge. The other flag keeps its value.
- R7: While `ext_level_mode` is 1, the external flag reads 0 from the next edge onward, and edge pulses do not set it.
- R8: A request is raised only when `glb_ie` is 1 and a source is both flagged and enabled. The external source is enabled by `ext_ie` and the timer by the timer enable bit. Vector 1 means external, vector 2 means timer, and vector 0 means no request.
- R9: When both sources request, `irq_vec` is 1.
- R10: In level mode, the external request equals `ext_level_active` AND `ext_ie` AND `glb_ie`.
- R11: A set pulse arriving in the same cycle as a write-one-to-clear or an acknowledge of that flag leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 6 | I/O address |
| io_wdata | input | 8 | Write data |
| io_we | input | 1 | Write strobe |
| io_re | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, combinational |
| ext_edge_pulse | input | 1 | One-cycle pulse from the pin edge detector |
| ext_level_mode | input | 1 | 1 selects level-triggered external interrupt |
| ext_level_active | input | 1 | Pin is at its active level |
| tmr_ovf_pulse | input | 1 | One-cycle timer overflow pulse |
| glb_ie | input | 1 | Global interrupt enable |
| ext_ie | input | 1 | External interrupt enable |
| vec_ack | input | 1 | Core is taking the vector on `irq_vec` |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 4 | Vector number, 0 when idle |

## Verification
The request logic is tested by holding a flag set and switching the global enable, the per-source enable and the second source one at a time. This separates a gating fault from a priority fault. The flags are cleared by a write of all bits except the flag bit, then by the flag bit alone, and then by acknowledges in sequence. These three patterns tell a wrong bit position, a missing clear and an acknowledge that clears the wrong source apart. Set pulses are also made to coincide with each kind of clear, and edge pulses are sent while in level mode. These cases show whether the hold and the set-over-clear precedence are ordered correctly.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
   localparam int unsigned SRC_EXT = 0;
   localparam int unsigned SRC_TMR = 1;
   localparam int unsigned NUM_SRC = 2;

   typedef struct packed {
      logic set;
      logic w1c;
      logic ack;
      logic hold;
   } flag_ctl_t;

   function automatic bit addr_hit(input logic [15:0] a, input logic [15:0] b);
      return a == b;
   endfunction
endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
   input  logic                    clk,
   input  logic                    rst_n,
   input  irq_unit_pkg::flag_ctl_t ctl_i,
   output logic                    q_o
);
   logic q_d;

   always_comb begin
      if (ctl_i.hold)                   q_d = 1'b0;
      else if (ctl_i.set)               q_d = 1'b1;
      else if (ctl_i.w1c || ctl_i.ack)  q_d = 1'b0;
      else                              q_d = q_o;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= q_d;
   end

   // R4 R11
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_i.set && !ctl_i.hold |=> q_o);
   // R5 R6
   clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_i.w1c || ctl_i.ack) && !ctl_i.set |=> !q_o);
   // R7
   hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_i.hold |=> !q_o);
   // R5
   idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_i.set && !ctl_i.w1c && !ctl_i.ack && !ctl_i.hold |=> $stable(q_o));
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
   parameter int unsigned VEC_W  = 4,
   parameter int unsigned HI_VEC = 1,
   parameter int unsigned LO_VEC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_hi_i,
   input  logic             req_lo_i,
   output logic             irq_o,
   output logic [VEC_W-1:0] vec_o
);
   localparam logic [VEC_W-1:0] HI_CODE = VEC_W'(HI_VEC);
   localparam logic [VEC_W-1:0] LO_CODE = VEC_W'(LO_VEC);

   always_comb begin
      irq_o = req_hi_i | req_lo_i;
      if (req_hi_i)      vec_o = HI_CODE;
      else if (req_lo_i) vec_o = LO_CODE;
      else               vec_o = '0;
   end

   // R9
   hi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_hi_i && req_lo_i |-> vec_o == HI_CODE);
   // R8
   idle_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_o |-> vec_o == '0);
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux #(
   parameter int unsigned ADDR_W  = 6,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned NUM_REG = 3,
   parameter logic [NUM_REG*ADDR_W-1:0] ADDRS = '0,
   parameter logic [NUM_REG*DATA_W-1:0] MASKS = '0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       re_i,
   input  logic [ADDR_W-1:0]          addr_i,
   input  logic [NUM_REG*DATA_W-1:0]  regs_i,
   output logic [DATA_W-1:0]          rdata_o
);
   logic [NUM_REG-1:0]             hit;
   logic [NUM_REG*DATA_W-1:0]      gated;

   for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
      assign hit[g] = re_i && (addr_i == ADDRS[g*ADDR_W +: ADDR_W]);
      assign gated[g*DATA_W +: DATA_W] = hit[g]
         ? (regs_i[g*DATA_W +: DATA_W] & MASKS[g*DATA_W +: DATA_W]) : '0;
   end

   always_comb begin
      rdata_o = '0;
      for (int i = 0; i < NUM_REG; i++) rdata_o |= gated[i*DATA_W +: DATA_W];
   end

   // R2
   one_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));
   // R2
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit == '0 |-> rdata_o == '0);
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit #(
   parameter int unsigned ADDR_W   = 6,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned VEC_W    = 4,
   parameter int unsigned EXT_ADDR = 'h3A,
   parameter int unsigned MSK_ADDR = 'h39,
   parameter int unsigned TIF_ADDR = 'h38,
   parameter int unsigned EXT_BIT  = 6,
   parameter int unsigned TOV_BIT  = 1,
   parameter int unsigned TOIE_BIT = 1,
   parameter int unsigned EXT_VEC  = 1,
   parameter int unsigned TMR_VEC  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [DATA_W-1:0] io_wdata,
   input  logic              io_we,
   input  logic              io_re,
   output logic [DATA_W-1:0] io_rdata,
   input  logic              ext_edge_pulse,
   input  logic              ext_level_mode,
   input  logic              ext_level_active,
   input  logic              tmr_ovf_pulse,
   input  logic              glb_ie,
   input  logic              ext_ie,
   input  logic              vec_ack,
   output logic              irq_req,
   output logic [VEC_W-1:0]  irq_vec
);
   import irq_unit_pkg::*;

   localparam logic [ADDR_W-1:0] A_EXT = ADDR_W'(EXT_ADDR);
   localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(MSK_ADDR);
   localparam logic [ADDR_W-1:0] A_TIF = ADDR_W'(TIF_ADDR);
   localparam logic [DATA_W-1:0] M_EXT = DATA_W'(1) << EXT_BIT;
   localparam logic [DATA_W-1:0] M_MSK = DATA_W'(1) << TOIE_BIT;
   localparam logic [DATA_W-1:0] M_TIF = DATA_W'(1) << TOV_BIT;
   localparam logic [VEC_W-1:0]  V_EXT = VEC_W'(EXT_VEC);
   localparam logic [VEC_W-1:0]  V_TMR = VEC_W'(TMR_VEC);

   if (EXT_BIT >= DATA_W || TOV_BIT >= DATA_W || TOIE_BIT >= DATA_W) begin : g_bad_bit
      $error("irq_flag_unit: bit position outside data width");
   end
   if (EXT_ADDR >= 2**ADDR_W || MSK_ADDR >= 2**ADDR_W || TIF_ADDR >= 2**ADDR_W) begin : g_bad_addr
      $error("irq_flag_unit: address outside address width");
   end
   if (EXT_ADDR == MSK_ADDR || EXT_ADDR == TIF_ADDR || MSK_ADDR == TIF_ADDR) begin : g_dup_addr
      $error("irq_flag_unit: register addresses collide");
   end
   if (EXT_VEC == 0 || TMR_VEC == 0 || EXT_VEC == TMR_VEC ||
       EXT_VEC >= 2**VEC_W || TMR_VEC >= 2**VEC_W) begin : g_bad_vec
      $error("irq_flag_unit: vector numbers invalid");
   end

   logic                wr_ext, wr_msk, wr_tif;
   logic [DATA_W-1:0]   msk_q;
   logic [NUM_SRC-1:0]  flag_q;
   flag_ctl_t           ctl [NUM_SRC];
   logic                req_ext, req_tmr;
   logic                take;

   assign wr_ext = io_we && (io_addr == A_EXT);
   assign wr_msk = io_we && (io_addr == A_MSK);
   assign wr_tif = io_we && (io_addr == A_TIF);
   assign take   = vec_ack && irq_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      msk_q <= '0;
      else if (wr_msk) msk_q <= io_wdata & M_MSK;
   end

   always_comb begin
      ctl[SRC_EXT].set  = ext_edge_pulse;
      ctl[SRC_EXT].w1c  = wr_ext && io_wdata[EXT_BIT];
      ctl[SRC_EXT].ack  = take && (irq_vec == V_EXT);
      ctl[SRC_EXT].hold = ext_level_mode;
      ctl[SRC_TMR].set  = tmr_ovf_pulse;
      ctl[SRC_TMR].w1c  = wr_tif && io_wdata[TOV_BIT];
      ctl[SRC_TMR].ack  = take && (irq_vec == V_TMR);
      ctl[SRC_TMR].hold = 1'b0;
   end

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_flag
      irq_flag_cell u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .ctl_i (ctl[s]),
         .q_o   (flag_q[s])
      );
   end

   assign req_ext = glb_ie && ext_ie &&
                    (ext_level_mode ? ext_level_active : flag_q[SRC_EXT]);
   assign req_tmr = glb_ie && msk_q[TOIE_BIT] && flag_q[SRC_TMR];

   irq_prio_sel #(
      .VEC_W  (VEC_W),
      .HI_VEC (EXT_VEC),
      .LO_VEC (TMR_VEC)
   ) u_prio (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_hi_i (req_ext),
      .req_lo_i (req_tmr),
      .irq_o    (irq_req),
      .vec_o    (irq_vec)
   );

   irq_read_mux #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .NUM_REG (3),
      .ADDRS   ({A_TIF, A_MSK, A_EXT}),
      .MASKS   ({M_TIF, M_MSK, M_EXT})
   ) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .re_i    (io_re),
      .addr_i  (io_addr),
      .regs_i  ({(flag_q[SRC_TMR] ? M_TIF : '0), msk_q,
                 (flag_q[SRC_EXT] ? M_EXT : '0)}),
      .rdata_o (io_rdata)
   );

   // R8
   glb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_ie |-> !irq_req);
   // R3
   msk_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_msk |=> msk_q[TOIE_BIT] == $past(io_wdata[TOIE_BIT]));
   // R10
   level_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_level_mode && ext_level_active && ext_ie && glb_ie |-> irq_req && irq_vec == V_EXT);
   // R7
   level_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_level_mode && $past(ext_level_mode) |-> !flag_q[SRC_EXT]);
endmodule

// File: tb/tb_irq_flag_unit.sv
module tb_irq_flag_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] io_addr = '0;
   logic [7:0] io_wdata = '0;
   logic       io_we = 1'b0, io_re = 1'b0;
   logic [7:0] io_rdata;
   logic       ext_edge_pulse = 1'b0, ext_level_mode = 1'b0, ext_level_active = 1'b0;
   logic       tmr_ovf_pulse = 1'b0, glb_ie = 1'b0, ext_ie = 1'b0, vec_ack = 1'b0;
   logic       irq_req;
   logic [3:0] irq_vec;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   irq_flag_unit dut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
      .io_we(io_we), .io_re(io_re), .io_rdata(io_rdata),
      .ext_edge_pulse(ext_edge_pulse), .ext_level_mode(ext_level_mode),
      .ext_level_active(ext_level_active), .tmr_ovf_pulse(tmr_ovf_pulse),
      .glb_ie(glb_ie), .ext_ie(ext_ie), .vec_ack(vec_ack),
      .irq_req(irq_req), .irq_vec(irq_vec)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic rd(input logic [5:0] a, output logic [7:0] v);
      io_addr = a; io_re = 1'b1;
      #1;
      v = io_rdata;
      io_re = 1'b0;
   endtask

   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      io_addr = a; io_wdata = d; io_we = 1'b1;
      tick();
      io_we = 1'b0;
   endtask

   task automatic pulse_ext();
      ext_edge_pulse = 1'b1; tick(); ext_edge_pulse = 1'b0;
   endtask

   task automatic pulse_tmr();
      tmr_ovf_pulse = 1'b1; tick(); tmr_ovf_pulse = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd(6'h3A, v); check("R1 ext flag reg", v, 0);
      rd(6'h39, v); check("R1 mask reg", v, 0);
      rd(6'h38, v); check("R1 timer flag reg", v, 0);
      #1; check("R1 irq_req", irq_req, 0); check("R1 irq_vec", irq_vec, 0);
   endtask

   task automatic t_mask();
      logic [7:0] v;
      wr(6'h39, 8'hFF); rd(6'h39, v); check("R3 mask write ones", v, 8'h02);
      wr(6'h39, 8'hFD); rd(6'h39, v); check("R3 mask bit1 zero", v, 8'h00);
      wr(6'h39, 8'h02); rd(6'h39, v); check("R3 mask bit1 only", v, 8'h02);
      wr(6'h39, 8'h00);
   endtask

   task automatic t_set_clear();
      logic [7:0] v;
      pulse_ext(); rd(6'h3A, v); check("R4 ext flag set (R2 bit6)", v, 8'h40);
      pulse_tmr(); rd(6'h38, v); check("R4 timer flag set (R2 bit1)", v, 8'h02);
      rd(6'h10, v); check("R2 unmapped address", v, 0);
      wr(6'h3A, 8'hBF); rd(6'h3A, v); check("R5 other bits no clear", v, 8'h40);
      wr(6'h3A, 8'h40); rd(6'h3A, v); check("R5 w1c ext", v, 0);
      rd(6'h38, v); check("R5 timer untouched", v, 8'h02);
      wr(6'h38, 8'h00); rd(6'h38, v); check("R5 write zero keeps", v, 8'h02);
      wr(6'h38, 8'h02); rd(6'h38, v); check("R5 w1c timer", v, 0);
   endtask

   task automatic t_request();
      pulse_tmr();
      wr(6'h39, 8'h02);
      glb_ie = 1'b0; #1; check("R8 no global enable", irq_req, 0);
      glb_ie = 1'b1; #1; check("R8 timer req", irq_req, 1); check("R8 timer vec", irq_vec, 2);
      wr(6'h39, 8'h00); #1; check("R8 timer masked", irq_req, 0); check("R8 idle vec", irq_vec, 0);
      wr(6'h39, 8'h02);
   endtask

   task automatic t_prio_ack();
      logic [7:0] v;
      pulse_ext(); ext_ie = 1'b0; #1;
      check("R8 ext disabled gives timer", irq_vec, 2);
      ext_ie = 1'b1; #1; check("R9 ext wins", irq_vec, 1);
      vec_ack = 1'b1; tick(); vec_ack = 1'b0;
      rd(6'h3A, v); check("R6 ack clears ext", v, 0);
      rd(6'h38, v); check("R6 ack keeps timer", v, 8'h02);
      check("R6 now timer vec", irq_vec, 2);
      vec_ack = 1'b1; tick(); vec_ack = 1'b0;
      rd(6'h38, v); check("R6 ack clears timer", v, 0);
      check("R6 no req left", irq_req, 0);
   endtask

   task automatic t_level();
      logic [7:0] v;
      pulse_ext();
      ext_level_mode = 1'b1; #1;
      check("R10 level inactive no req", irq_req, 0);
      tick(); rd(6'h3A, v); check("R7 flag held zero", v, 0);
      pulse_ext(); rd(6'h3A, v); check("R7 pulse ignored", v, 0);
      ext_level_active = 1'b1; #1;
      check("R10 level req", irq_req, 1); check("R10 level vec", irq_vec, 1);
      glb_ie = 1'b0; #1; check("R10 level gated", irq_req, 0);
      glb_ie = 1'b1; ext_level_active = 1'b0; ext_level_mode = 1'b0; tick();
   endtask

   task automatic t_set_wins();
      logic [7:0] v;
      pulse_tmr();
      tmr_ovf_pulse = 1'b1; wr(6'h38, 8'h02); tmr_ovf_pulse = 1'b0;
      rd(6'h38, v); check("R11 set beats w1c", v, 8'h02);
      wr(6'h38, 8'h02);
      pulse_ext(); #1; check("R11 ext vec before ack", irq_vec, 1);
      ext_edge_pulse = 1'b1; vec_ack = 1'b1; tick(); ext_edge_pulse = 1'b0; vec_ack = 1'b0;
      rd(6'h3A, v); check("R11 set beats ack", v, 8'h40);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #3; t_reset();
      tick(); rst_n = 1'b1; tick();
      t_reset();
      t_mask();
      t_set_clear();
      t_request();
      t_prio_ack();
      t_level();
      t_set_wins();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule